// File: doc/BRIEF.md
# Serial Asynchronous Receiver with Error Flags

This block receives asynchronous serial frames on a single input line. Each frame has one low start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit. The line passes through a two-flop synchronizer. It is then sampled at sixteen times the bit rate, paced by a one-cycle `baud_tick` input that an outside divider supplies. Each finished byte goes into a single-entry receive buffer. A status register reports whether the buffer holds unread data and whether a parity, framing or overrun error has occurred.

Software reaches both registers through a plain register-read port: `rd_en` with `rd_sel` selecting the register, and the data on `rd_data` in the same cycle. There is no stream handshake and no back-pressure. The line cannot be stalled, so a frame that completes while the buffer is still full is dropped and marked as an overrun. The error flags are sticky. They clear only when the receive buffer is read after a status read. A one-cycle `rx_irq` pulse marks the end of every frame.

Top module: `serial_rx_errflags`

## Requirements
- R1: After reset the status register reads 0x00 and `rx_irq` is low.
- R2: A frame with eight data bits, least significant bit first, sampled near mid-bit at 16 ticks per bit, is stored in the receive buffer and read back with `rd_sel`=1.
- R3: Status bit 0 (buffer full) is set when a byte is written into the buffer and cleared when the buffer is read.
- R4: When a frame completes while status bit 0 is set, status bit 3 (overrun) is set, the new byte is discarded and the buffer keeps its old contents.
- R5: With `par_en`=1, status bit 1 (parity error) is set when the received parity bit differs from the expected one. The expected bit is the XOR of the data bits for even parity (`par_odd`=0) and its inverse for odd parity. With `par_en`=0 no parity bit is received and bit 1 is never set.
- R6: The error flags (status bits 1 to 3) clear only on a buffer read that follows a status read. A buffer read with no status read before it leaves them set.
- R7: `rx_irq` is a single-cycle pulse, given once for each completed frame, including errored and overrun frames.
- R8: Status bit 2 (framing error) is set when the stop bit is sampled low.
- R9: A low level that has gone high again by the start bit's midpoint is treated as noise: no frame, no interrupt, no status change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_in | input | 1 | Serial receive line, idle high |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| par_en | input | 1 | 1 = the frame carries a parity bit |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 1 | 0 = status register, 1 = receive buffer |
| rd_data | output | 8 | Read data for the selected register, combinational |
| rx_irq | output | 1 | Receive-complete pulse |

## Verification
The embedded assertions watch, on every cycle, that the completion pulse never lasts two cycles, that an overrun leaves the buffer intact and raises its flag, that a write into an empty buffer sets the full bit with the new byte, and that a buffer read with no armed status read never lowers an error flag. Some properties can only be shown by the bench's directed frames: correct bit order and mid-bit sampling, even and odd parity decisions, detection of a low stop bit, rejection of a short start glitch, and the full status-then-buffer clear sequence.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;

  localparam int STAT_FULL = 0;
  localparam int STAT_PERR = 1;
  localparam int STAT_FERR = 2;
  localparam int STAT_OERR = 3;

  localparam logic SEL_STATUS = 1'b0;
  localparam logic SEL_BUFFER = 1'b1;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], d_in};
  end

  assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx,
  input  logic              tick,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              frm_valid,
  output logic [DATA_W-1:0] frm_data,
  output logic              frm_perr,
  output logic              frm_ferr
);
  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVS/2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVS - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shift_q;
  logic              par_bit_q;
  logic              mid_hit, bit_hit;

  assign mid_hit = tick && (cnt_q == MID_CNT);
  assign bit_hit = tick && (cnt_q == LAST_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= RX_IDLE;
      cnt_q     <= '0;
      idx_q     <= '0;
      shift_q   <= '0;
      par_bit_q <= 1'b0;
      frm_valid <= 1'b0;
      frm_perr  <= 1'b0;
      frm_ferr  <= 1'b0;
    end else begin
      frm_valid <= 1'b0;
      case (state_q)
        RX_IDLE: begin
          cnt_q <= '0;
          if (tick && !rx) state_q <= RX_START;
        end
        RX_START: begin
          if (mid_hit) begin
            cnt_q   <= '0;
            idx_q   <= '0;
            state_q <= rx ? RX_IDLE : RX_DATA;
          end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (bit_hit) begin
            cnt_q   <= '0;
            shift_q <= {rx, shift_q[DATA_W-1:1]};
            idx_q   <= idx_q + 1'b1;
            if (idx_q == LAST_IDX) state_q <= par_en ? RX_PAR : RX_STOP;
          end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_PAR: begin
          if (bit_hit) begin
            cnt_q     <= '0;
            par_bit_q <= rx;
            state_q   <= RX_STOP;
          end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (bit_hit) begin
            cnt_q     <= '0;
            frm_valid <= 1'b1;
            frm_ferr  <= !rx;
            frm_perr  <= par_en && (par_bit_q != ((^shift_q) ^ par_odd));
            state_q   <= RX_IDLE;
          end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  assign frm_data = shift_q;

  AST_FRAME_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> !frm_valid); // R7
  AST_PERR_NEEDS_PAR: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !par_en) |-> !frm_perr); // R5
endmodule

// File: rtl/rx_status_regs.sv
module rx_status_regs
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_valid,
  input  logic [DATA_W-1:0] frm_data,
  input  logic              frm_perr,
  input  logic              frm_ferr,
  input  logic              rd_en,
  input  logic              rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  logic [DATA_W-1:0] buf_q;
  logic full_q, perr_q, ferr_q, oerr_q, armed_q;
  logic rd_stat, rd_buf, clr_flags, wr_buf, ovr;

  assign rd_stat   = rd_en && (rd_sel == SEL_STATUS);
  assign rd_buf    = rd_en && (rd_sel == SEL_BUFFER);
  assign clr_flags = rd_buf && armed_q;
  assign ovr       = frm_valid && full_q;
  assign wr_buf    = frm_valid && !full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q   <= '0;
      full_q  <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      oerr_q  <= 1'b0;
      armed_q <= 1'b0;
      irq     <= 1'b0;
    end else begin
      irq <= frm_valid;
      if (wr_buf) buf_q <= frm_data;
      full_q  <= wr_buf || ovr || (full_q && !rd_buf);
      // a flag being set in this cycle wins over the clear
      perr_q  <= (wr_buf && frm_perr) || (perr_q && !clr_flags);
      ferr_q  <= (wr_buf && frm_ferr) || (ferr_q && !clr_flags);
      oerr_q  <= ovr || (oerr_q && !clr_flags);
      if (rd_stat)     armed_q <= 1'b1;
      else if (rd_buf) armed_q <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_sel == SEL_BUFFER) begin
      rd_data = buf_q;
    end else begin
      rd_data[STAT_FULL] = full_q;
      rd_data[STAT_PERR] = perr_q;
      rd_data[STAT_FERR] = ferr_q;
      rd_data[STAT_OERR] = oerr_q;
    end
  end

  AST_OVR_KEEPS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && full_q) |=> ($stable(buf_q) && oerr_q)); // R4
  AST_FULL_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !full_q) |=> (full_q && buf_q == $past(frm_data))); // R3
  AST_NO_UNARMED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_buf && !armed_q) |=> (!$fell(perr_q) && !$fell(ferr_q) && !$fell(oerr_q))); // R6
endmodule

// File: rtl/serial_rx_errflags.sv
module serial_rx_errflags #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_in,
  input  logic              baud_tick,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              rd_en,
  input  logic              rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              rx_irq
);
  logic              rx_s;
  logic              frm_valid, frm_perr, frm_ferr;
  logic [DATA_W-1:0] frm_data;

  rx_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(rx_in), .d_out(rx_s)
  );

  rx_framer #(.DATA_W(DATA_W), .OVS(OVS)) u_framer (
    .clk(clk), .rst_n(rst_n), .rx(rx_s), .tick(baud_tick),
    .par_en(par_en), .par_odd(par_odd),
    .frm_valid(frm_valid), .frm_data(frm_data),
    .frm_perr(frm_perr), .frm_ferr(frm_ferr)
  );

  rx_status_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .frm_valid(frm_valid), .frm_data(frm_data),
    .frm_perr(frm_perr), .frm_ferr(frm_ferr),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .irq(rx_irq)
  );
endmodule

// File: tb/sim_serial_rx_errflags.sv
module sim_serial_rx_errflags;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV       = 2;
  localparam int OVS        = 16;
  localparam int BIT_CLKS   = OVS * TDIV;

  logic clk = 1'b0, rst_n = 1'b0, rx_in = 1'b1, baud_tick = 1'b0;
  logic par_en = 1'b0, par_odd = 1'b0, rd_en = 1'b0, rd_sel = 1'b0;
  logic [7:0] rd_data;
  logic rx_irq;
  int errors = 0, checks = 0, irq_cnt = 0, tdiv_cnt = 0;
  bit done = 0;

  serial_rx_errflags u0 (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .baud_tick(baud_tick),
    .par_en(par_en), .par_odd(par_odd), .rd_en(rd_en), .rd_sel(rd_sel),
    .rd_data(rd_data), .rx_irq(rx_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    tdiv_cnt  <= (tdiv_cnt == TDIV-1) ? 0 : tdiv_cnt + 1;
    baud_tick <= (tdiv_cnt == TDIV-1);
    if (rst_n && rx_irq) irq_cnt <= irq_cnt + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic sel, output logic [7:0] val);
    @(negedge clk);
    rd_en = 1'b1; rd_sel = sel;
    #1 val = rd_data;
    @(negedge clk);
    rd_en = 1'b0; rd_sel = 1'b0;
  endtask

  task automatic drive_bit(input logic v, input int clks);
    rx_in = v;
    repeat (clks) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit with_par, input logic pbit,
                      input logic stop_v, input int stop_clks);
    @(negedge clk);
    drive_bit(1'b0, BIT_CLKS);
    for (int i = 0; i < 8; i++) drive_bit(d[i], BIT_CLKS);
    if (with_par) drive_bit(pbit, BIT_CLKS);
    drive_bit(stop_v, stop_clks);
    drive_bit(1'b1, 2*BIT_CLKS);
  endtask

  task automatic clear_all();
    logic [7:0] v;
    rd(1'b0, v);
    rd(1'b1, v);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(1'b0, v);
    chk("R1 status after reset", v, 8'h00);
    chk("R1 irq after reset", rx_irq, 0);
  endtask

  task automatic t_basic();
    logic [7:0] v;
    int n0 = irq_cnt;
    par_en = 1'b0;
    send(8'hA5, 0, 1'b0, 1'b1, BIT_CLKS);
    chk("R7 one irq per frame", irq_cnt - n0, 1);
    rd(1'b0, v); chk("R3 full bit set", v, 8'h01);
    rd(1'b1, v); chk("R2 data A5", v, 8'hA5);
    rd(1'b0, v); chk("R3 full bit cleared by read", v, 8'h00);
    send(8'h01, 0, 1'b0, 1'b1, BIT_CLKS);
    rd(1'b1, v); chk("R2 data 01 lsb first", v, 8'h01);
    clear_all();
  endtask

  task automatic t_parity();
    logic [7:0] v;
    par_en = 1'b1; par_odd = 1'b0;
    send(8'h3C, 1, 1'b0, 1'b1, BIT_CLKS);
    rd(1'b0, v); chk("R5 even parity ok", v, 8'h01);
    rd(1'b1, v); chk("R2 data 3C with parity", v, 8'h3C);
    send(8'h3C, 1, 1'b1, 1'b1, BIT_CLKS);
    rd(1'b1, v); chk("R6 buffer read unarmed data", v, 8'h3C);
    rd(1'b0, v); chk("R6 perr kept after unarmed read", v, 8'h02);
    rd(1'b1, v);
    rd(1'b0, v); chk("R6 perr cleared after status then buffer", v, 8'h00);
    par_odd = 1'b1;
    send(8'h07, 1, 1'b0, 1'b1, BIT_CLKS);
    rd(1'b0, v); chk("R5 odd parity ok", v, 8'h01);
    rd(1'b1, v);
    send(8'h07, 1, 1'b1, 1'b1, BIT_CLKS);
    rd(1'b0, v); chk("R5 odd parity error", v, 8'h03);
    rd(1'b1, v);
    par_en = 1'b0; par_odd = 1'b0;
  endtask

  task automatic t_framing();
    logic [7:0] v;
    int n0 = irq_cnt;
    send(8'h55, 0, 1'b0, 1'b0, (OVS/2 + 2) * TDIV);
    chk("R7 irq for errored frame", irq_cnt - n0, 1);
    rd(1'b0, v); chk("R8 framing error", v, 8'h05);
    rd(1'b1, v); chk("R8 data kept 55", v, 8'h55);
    rd(1'b0, v); chk("R6 ferr cleared", v, 8'h00);
  endtask

  task automatic t_overrun();
    logic [7:0] v;
    int n0 = irq_cnt;
    send(8'h11, 0, 1'b0, 1'b1, BIT_CLKS);
    send(8'h22, 0, 1'b0, 1'b1, BIT_CLKS);
    chk("R7 irq for overrun frame", irq_cnt - n0, 2);
    rd(1'b0, v); chk("R4 overrun flag", v, 8'h09);
    rd(1'b1, v); chk("R4 old byte kept", v, 8'h11);
    rd(1'b0, v); chk("R6 oerr cleared", v, 8'h00);
  endtask

  task automatic t_glitch();
    logic [7:0] v;
    int n0 = irq_cnt;
    @(negedge clk);
    drive_bit(1'b0, 4 * TDIV);
    drive_bit(1'b1, 3 * BIT_CLKS);
    chk("R9 no irq for glitch", irq_cnt - n0, 0);
    rd(1'b0, v); chk("R9 status unchanged", v, 8'h00);
    send(8'hC3, 0, 1'b0, 1'b1, BIT_CLKS);
    rd(1'b1, v); chk("R9 frame after glitch", v, 8'hC3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic();
    t_parity();
    t_framing();
    t_overrun();
    t_glitch();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule